// File: doc/BRIEF.md
# Upper Bound Check Unit

This execution unit carries out the two upper-bound pointer check instructions. Each request gives a decoded third opcode byte, a bounds register index, a 64-bit operand, the processor mode and the prefix state. The operand is either a register value or an effective address that was computed upstream. The unit compares that operand, unsigned, against the upper bound held in a small internal bounds file. The bound is used inverted for one opcode and as stored for the other. A failed check raises a bounds-range fault and sets the bounds status register to 0x01.

The prefix, mode and register-index conditions are checked first. When any of them is illegal, the unit raises an invalid-opcode fault in place of the compare. That fault suppresses the bounds fault and leaves the status register as it was. The unit never issues a memory access. The arithmetic flags pass through it unchanged in every case. A write port lets the surrounding logic, or a bench, preload the upper-bound entries.

Top module: `ubchk_unit`

## Requirements
- R1: A write with `bnd_we_i` high stores `bnd_wdata_i` into the entry `bnd_waddr_i`. Checks issued after that edge use the new value. All entries reset to 0.
- R2: Opcode byte 0x1A uses the bitwise NOT of the stored entry as the effective bound. The bounds-range fault is raised when the operand is unsigned-greater than that effective bound.
- R3: Opcode byte 0x1B uses the stored entry unchanged as the effective bound, with the same unsigned strictly-greater rule.
- R4: An operand equal to the effective bound passes the check.
- R5: Outside 64-bit mode (`mode_i` values 0 real, 1 virtual-8086, 2 protected/compatibility), only bits 31:0 of the operand and of the effective bound are compared. In 64-bit mode (`mode_i` = 3), all 64 bits are compared.
- R6: A bounds-range fault writes 0x01 into `bnd_status_o`. No other outcome changes it. It resets to 0x00.
- R7: A request with `lock_i` high raises the invalid-opcode fault.
- R8: Outside 64-bit mode, the fault is raised when bit 2 of `bnd_idx_i` is set. Bit 3 is ignored in those modes. In 64-bit mode, the fault is raised for any index from 4 to 15.
- R9: Outside 64-bit mode, the fault is raised when 16-bit addressing is in effect. That is the case when `cs_d_i` equals `adsz_ovr_i`: either the override is absent with a 16-bit default, or it is present with a 32-bit default.
- R10: Any opcode byte other than 0x1A or 0x1B raises the invalid-opcode fault.
- R11: An invalid-opcode fault keeps `br_o` low and leaves `bnd_status_o` unchanged, even when the operand would fail the compare.
- R12: The cycle after `valid_i` is sampled high, `done_o` is high for one cycle and carries the outcome on `ud_o` and `br_o`. With no request, `done_o`, `ud_o` and `br_o` are low. All three reset to low.
- R13: `flags_o` equals `flags_i` at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bnd_we_i | input | 1 | Bounds entry write enable |
| bnd_waddr_i | input | 2 | Bounds entry write index |
| bnd_wdata_i | input | 64 | Upper-bound value to store |
| valid_i | input | 1 | Check request |
| opc_i | input | 8 | Third opcode byte (0x1A inverted, 0x1B plain) |
| bnd_idx_i | input | 4 | Bounds register index, bit 3 from the register-extension prefix |
| operand_i | input | 64 | Register value or precomputed effective address |
| mode_i | input | 2 | 0 real, 1 virtual-8086, 2 protected/compatibility, 3 64-bit |
| cs_d_i | input | 1 | Default code size is 32-bit |
| adsz_ovr_i | input | 1 | Address-size override prefix present |
| lock_i | input | 1 | LOCK prefix present |
| flags_i | input | 6 | Arithmetic flags in |
| flags_o | output | 6 | Arithmetic flags out, unchanged |
| done_o | output | 1 | Result valid, one cycle after the request |
| ud_o | output | 1 | Invalid-opcode fault |
| br_o | output | 1 | Bounds-range fault |
| bnd_status_o | output | 8 | Bounds status register |

## Verification
The assertions check, on every cycle, the properties that hold regardless of the bound values:
- the one-cycle request-to-done timing and fault qualification;
- that the two faults never occur together;
- that the status register changes only with a bounds fault and reads 0x01 when it does;
- that LOCK and the illegal-index cases always yield the invalid-opcode fault.

The compare result itself depends on the stored bound, the opcode variant and the operand width, so only the bench scenarios can show it. Those scenarios cover operands just below, at and above the inverted and plain bounds, 32-bit operands with random upper halves, and freshly rewritten entries.

// File: rtl/ubchk_pkg.sv
package ubchk_pkg;
  typedef enum logic [1:0] {
    MODE_REAL = 2'd0,
    MODE_V86  = 2'd1,
    MODE_PROT = 2'd2,
    MODE_LONG = 2'd3
  } cpu_mode_e;

  localparam logic [7:0] OPC_CHK_INV = 8'h1A;
  localparam logic [7:0] OPC_CHK_RAW = 8'h1B;
  localparam logic [7:0] STAT_BR     = 8'h01;
endpackage

// File: rtl/ubchk_bnd_file.sv
module ubchk_bnd_file #(
  parameter int unsigned NBND = 4,
  parameter int unsigned W    = 64,
  localparam int unsigned AW  = (NBND > 1) ? $clog2(NBND) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] ent_q [NBND];

  for (genvar g = 0; g < NBND; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ent_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))           ent_q[g] <= wdata_i;
    end
  end

  assign rdata_o = ent_q[raddr_i];
endmodule

// File: rtl/ubchk_fault_dec.sv
module ubchk_fault_dec
  import ubchk_pkg::*;
#(
  parameter int unsigned IDXW = 4,
  parameter int unsigned NBND = 4
) (
  input  logic [7:0]      opc_i,
  input  logic [IDXW-1:0] idx_i,
  input  cpu_mode_e       mode_i,
  input  logic            cs_d_i,
  input  logic            adsz_ovr_i,
  input  logic            lock_i,
  output logic            ud_o,
  output logic            inv_o,
  output logic            w64_o
);
  logic opc_bad, idx_bad, asz_bad;

  always_comb begin
    w64_o   = (mode_i == MODE_LONG);
    inv_o   = (opc_i == OPC_CHK_INV);
    opc_bad = (opc_i != OPC_CHK_INV) && (opc_i != OPC_CHK_RAW);
    // without REX only the low three index bits exist
    if (w64_o) idx_bad = (32'(idx_i) >= NBND);
    else       idx_bad = (32'(idx_i[IDXW-2:0]) >= NBND);
    // 16-bit addressing in effect when default size and override agree
    asz_bad = !w64_o && (cs_d_i == adsz_ovr_i);
    ud_o    = lock_i || opc_bad || idx_bad || asz_bad;
  end
endmodule

// File: rtl/ubchk_cmp.sv
module ubchk_cmp #(
  parameter int unsigned W  = 64,
  localparam int unsigned HW = W / 2
) (
  input  logic [W-1:0] opnd_i,
  input  logic [W-1:0] bnd_i,
  input  logic         inv_i,
  input  logic         w64_i,
  output logic         over_o
);
  logic [W-1:0] eff;

  always_comb begin
    eff = inv_i ? ~bnd_i : bnd_i;
    if (w64_i) over_o = (opnd_i > eff);
    else       over_o = (opnd_i[HW-1:0] > eff[HW-1:0]);
  end
endmodule

// File: rtl/ubchk_unit.sv
module ubchk_unit
  import ubchk_pkg::*;
#(
  parameter int unsigned NBND = 4,
  parameter int unsigned W    = 64,
  parameter int unsigned IDXW = 4,
  parameter int unsigned FLW  = 6,
  localparam int unsigned AW  = (NBND > 1) ? $clog2(NBND) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bnd_we_i,
  input  logic [AW-1:0]   bnd_waddr_i,
  input  logic [W-1:0]    bnd_wdata_i,
  input  logic            valid_i,
  input  logic [7:0]      opc_i,
  input  logic [IDXW-1:0] bnd_idx_i,
  input  logic [W-1:0]    operand_i,
  input  logic [1:0]      mode_i,
  input  logic            cs_d_i,
  input  logic            adsz_ovr_i,
  input  logic            lock_i,
  input  logic [FLW-1:0]  flags_i,
  output logic [FLW-1:0]  flags_o,
  output logic            done_o,
  output logic            ud_o,
  output logic            br_o,
  output logic [7:0]      bnd_status_o
);
  logic [W-1:0] bnd_rd;
  logic         ud_c, inv_c, w64_c, over_c;
  logic         done_q, ud_q, br_q;
  logic [7:0]   status_q;

  ubchk_bnd_file #(.NBND(NBND), .W(W)) u_file (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bnd_we_i),
    .waddr_i (bnd_waddr_i),
    .wdata_i (bnd_wdata_i),
    .raddr_i (bnd_idx_i[AW-1:0]),
    .rdata_o (bnd_rd)
  );

  ubchk_fault_dec #(.IDXW(IDXW), .NBND(NBND)) u_dec (
    .opc_i      (opc_i),
    .idx_i      (bnd_idx_i),
    .mode_i     (cpu_mode_e'(mode_i)),
    .cs_d_i     (cs_d_i),
    .adsz_ovr_i (adsz_ovr_i),
    .lock_i     (lock_i),
    .ud_o       (ud_c),
    .inv_o      (inv_c),
    .w64_o      (w64_c)
  );

  ubchk_cmp #(.W(W)) u_cmp (
    .opnd_i (operand_i),
    .bnd_i  (bnd_rd),
    .inv_i  (inv_c),
    .w64_i  (w64_c),
    .over_o (over_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q   <= 1'b0;
      ud_q     <= 1'b0;
      br_q     <= 1'b0;
      status_q <= '0;
    end else begin
      done_q <= valid_i;
      ud_q   <= valid_i && ud_c;
      br_q   <= valid_i && !ud_c && over_c;
      if (valid_i && !ud_c && over_c) status_q <= STAT_BR;
    end
  end

  assign flags_o      = flags_i;
  assign done_o       = done_q;
  assign ud_o         = ud_q;
  assign br_o         = br_q;
  assign bnd_status_o = status_q;
endmodule

// File: rtl/ubchk_chk.sv
module ubchk_chk #(
  parameter int unsigned IDXW = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            valid_i,
  input logic [IDXW-1:0] bnd_idx_i,
  input logic [1:0]      mode_i,
  input logic            lock_i,
  input logic            done_o,
  input logic            ud_o,
  input logic            br_o,
  input logic [7:0]      bnd_status_o
);
  p_done_follows_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  p_done_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  p_fault_qual_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> (!ud_o && !br_o));
  p_ud_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_o |-> !br_o);
  p_ud_keeps_stat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ud_o |-> $stable(bnd_status_o));
  p_stat_on_br_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_o |-> (bnd_status_o == 8'h01));
  p_stat_only_br_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bnd_status_o) |-> br_o);
  p_lock_ud_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lock_i) |=> ud_o);
  p_idx_ud_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ((mode_i != 2'd3 && bnd_idx_i[2]) ||
                 (mode_i == 2'd3 && bnd_idx_i[IDXW-1:2] != '0))) |=> ud_o);
endmodule

bind ubchk_unit ubchk_chk #(.IDXW(IDXW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .bnd_idx_i    (bnd_idx_i),
  .mode_i       (mode_i),
  .lock_i       (lock_i),
  .done_o       (done_o),
  .ud_o         (ud_o),
  .br_o         (br_o),
  .bnd_status_o (bnd_status_o)
);

// File: tb/ubchk_unit_tb_top.sv
module ubchk_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bnd_we_i = 1'b0;
  logic [1:0]  bnd_waddr_i = '0;
  logic [63:0] bnd_wdata_i = '0;
  logic        valid_i = 1'b0;
  logic [7:0]  opc_i = 8'h1A;
  logic [3:0]  bnd_idx_i = '0;
  logic [63:0] operand_i = '0;
  logic [1:0]  mode_i = 2'd3;
  logic        cs_d_i = 1'b0;
  logic        adsz_ovr_i = 1'b0;
  logic        lock_i = 1'b0;
  logic [5:0]  flags_i = '0;
  logic [5:0]  flags_o;
  logic        done_o, ud_o, br_o;
  logic [7:0]  bnd_status_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] shadow [4];
  logic [7:0]  exp_status = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  ubchk_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .bnd_we_i(bnd_we_i), .bnd_waddr_i(bnd_waddr_i), .bnd_wdata_i(bnd_wdata_i),
    .valid_i(valid_i), .opc_i(opc_i), .bnd_idx_i(bnd_idx_i), .operand_i(operand_i),
    .mode_i(mode_i), .cs_d_i(cs_d_i), .adsz_ovr_i(adsz_ovr_i), .lock_i(lock_i),
    .flags_i(flags_i), .flags_o(flags_o),
    .done_o(done_o), .ud_o(ud_o), .br_o(br_o), .bnd_status_o(bnd_status_o)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_ud(logic [7:0] opc, logic [3:0] idx, logic [1:0] md,
                                  logic csd, logic ovr, logic lk);
    logic r;
    r = lk || (opc != 8'h1A && opc != 8'h1B);
    if (md == 2'd3) r = r || (idx >= 4'd4);
    else            r = r || idx[2] || (csd == ovr);
    return r;
  endfunction

  function automatic logic [63:0] eff_bound(logic [7:0] opc, logic [1:0] idx);
    return (opc == 8'h1A) ? ~shadow[idx] : shadow[idx];
  endfunction

  function automatic logic exp_br(logic [63:0] opnd, logic [63:0] eff, logic [1:0] md);
    if (md == 2'd3) return opnd > eff;
    return opnd[31:0] > eff[31:0];
  endfunction

  task automatic wr_bnd(logic [1:0] a, logic [63:0] d);
    @(negedge clk);
    bnd_we_i = 1'b1; bnd_waddr_i = a; bnd_wdata_i = d;
    @(negedge clk);
    bnd_we_i = 1'b0;
    shadow[a] = d;
  endtask

  task automatic issue(string req, logic [7:0] opc, logic [3:0] idx, logic [63:0] opnd,
                       logic [1:0] md, logic csd, logic ovr, logic lk);
    logic eu, eb;
    eu = exp_ud(opc, idx, md, csd, ovr, lk);
    eb = !eu && exp_br(opnd, eff_bound(opc, idx[1:0]), md);
    @(negedge clk);
    valid_i = 1'b1; opc_i = opc; bnd_idx_i = idx; operand_i = opnd;
    mode_i = md; cs_d_i = csd; adsz_ovr_i = ovr; lock_i = lk;
    flags_i = 6'($urandom);
    #1 check({req, " R13 flags"}, 64'(flags_o), 64'(flags_i));
    @(negedge clk);
    valid_i = 1'b0;
    if (eb) exp_status = 8'h01;
    check({req, " R12 done"}, 64'(done_o), 64'd1);
    check({req, " ud"}, 64'(ud_o), 64'(eu));
    check({req, " br"}, 64'(br_o), 64'(eb));
    check({req, " R6 status"}, 64'(bnd_status_o), 64'(exp_status));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 4; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    check("R12 reset done", 64'(done_o), 64'd0);
    check("R12 reset ud", 64'(ud_o), 64'd0);
    check("R12 reset br", 64'(br_o), 64'd0);
    check("R6 reset status", 64'(bnd_status_o), 64'd0);
    rst_ni = 1'b1;

    // R11: lock with a failing operand (bound 0 plain) before any fault
    issue("R11 R7 lock", 8'h1B, 4'd0, 64'hFFFF, 2'd3, 1'b0, 1'b0, 1'b1);
    issue("R11 R8 idx", 8'h1B, 4'd5, 64'hFFFF, 2'd3, 1'b0, 1'b0, 1'b0);
    issue("R11 R9 asz", 8'h1B, 4'd0, 64'hFFFF, 2'd2, 1'b1, 1'b1, 1'b0);
    issue("R11 R10 opc", 8'h1C, 4'd0, 64'hFFFF, 2'd3, 1'b0, 1'b0, 1'b0);

    wr_bnd(2'd1, 64'h0000_0000_0000_1000);
    wr_bnd(2'd2, ~64'h0000_0000_8000_0000);
    issue("R1 R3 R4 eq", 8'h1B, 4'd1, 64'h1000, 2'd3, 1'b0, 1'b0, 1'b0);
    issue("R2 R4 eq", 8'h1A, 4'd2, 64'h8000_0000, 2'd3, 1'b0, 1'b0, 1'b0);
    issue("R2 over", 8'h1A, 4'd2, 64'h8000_0001, 2'd3, 1'b0, 1'b0, 1'b0);
    issue("R3 over", 8'h1B, 4'd1, 64'h1001, 2'd3, 1'b0, 1'b0, 1'b0);
    issue("R5 hi ignored", 8'h1B, 4'd1, 64'hFFFF_0000_0000_0FFF, 2'd2, 1'b1, 1'b0, 1'b0);
    issue("R5 full in long", 8'h1B, 4'd1, 64'hFFFF_0000_0000_0FFF, 2'd3, 1'b0, 1'b0, 1'b0);
    issue("R8 bit3 ignored", 8'h1B, 4'd9, 64'h0FFF, 2'd0, 1'b0, 1'b1, 1'b0);
    issue("R8 idx4 legacy", 8'h1B, 4'd4, 64'h0, 2'd1, 1'b1, 1'b0, 1'b0);
    issue("R9 real16", 8'h1B, 4'd1, 64'h0, 2'd0, 1'b0, 1'b0, 1'b0);
    wr_bnd(2'd1, 64'h0000_0000_0000_0010);
    issue("R1 rewrite", 8'h1B, 4'd1, 64'h11, 2'd3, 1'b0, 1'b0, 1'b0);

    @(negedge clk);
    check("R12 idle done", 64'(done_o), 64'd0);

    for (int i = 0; i < 4; i++)
      wr_bnd(2'(i), {$urandom, $urandom});

    for (int n = 0; n < 400; n++) begin
      logic [7:0] opc; logic [3:0] idx; logic [1:0] md; logic [63:0] opnd, eff;
      int unsigned r;
      r   = $urandom;
      opc = (r[3:0] == 4'd0) ? 8'($urandom) : (r[4] ? 8'h1A : 8'h1B);
      idx = r[7] ? 4'($urandom) : {2'b00, r[6:5]};
      md  = r[9:8];
      eff = eff_bound(opc, idx[1:0]);
      case (r[11:10])
        2'd0: opnd = {$urandom, $urandom};
        2'd1: opnd = eff;
        2'd2: opnd = eff + 64'd1;
        default: opnd = eff - 64'd1;
      endcase
      if (md != 2'd3 && r[12]) opnd[63:32] = $urandom;
      if ((n % 50) == 25) wr_bnd(2'($urandom), {$urandom, $urandom});
      issue("R2 R3 R5 rand", opc, idx, opnd, md, r[13], r[14], (r[19:16] == 4'd0));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule